// File: doc/BRIEF.md
# Clock Setup Write Sequencer

This block sets up the clocking of a multi-port Ethernet switch by issuing an ordered list of 32-bit register writes. After a start pulse it visits the ports in order, from port 0 upwards. For each port it reads three settings: the interface mode (MII, RMII, RGMII or SGMII), the role (MAC or PHY) and the link speed. From these it decides which clock-routing, divider, PLL and pad registers to write, and in what order. Every data word is built inside the block. Target addresses come from a per-port address table, with one extra address for the shared PLL1 control register. Any table entry equal to the reserved marker turns the matching write into a no-op.

Writes leave on a request channel that uses a valid/ready handshake. The block raises `req_valid_o` and holds the address and data unchanged until `req_ready_i` is sampled high. The downstream side can stall by holding ready low for as long as it needs. The transfer completes on a rising clock edge where both valid and ready are high. On that same edge `req_err_i` reports whether the write failed. Configuration inputs must stay stable while `busy_o` is high. A run ends with a one-cycle `done_o` pulse, and `error_o` is raised in the same cycle if the run was aborted.

Top module: `clk_setup_seq`

## Requirements
- R1: While `req_valid_o` is high and `req_ready_i` is low, valid, `req_addr_o` and `req_data_o` hold their values into the next cycle. A write counts only on an edge where valid and ready are both high.
- R2: A clock-routing word is (source << 24) | 0x800, which means autoblock is set and power-down is clear. A divider word is 0x0A000800 | ((factor-1) << 2) | powered_down. This gives 0x0A000801 when the divider is off, 0x0A000800 for divide by 1 and 0x0A000824 for divide by 10. Source codes for port p are: TX input 2p, RX input 2p+1, PLL0 0x0B, PLL1 0x0E, divider output 0x11+p.
- R3: In MII mode (mode code 0) the writes are, in order: the divider (on with factor 1 in PHY role, off in MAC role), the MII TX clock (TX input for a MAC, divider output for a PHY) and the MII RX clock (RX input). In PHY role these are followed by the external TX clock and then the external RX clock, both set to the divider output.
- R4: In RMII mode (code 1) with MAC role, the writes are: 0x0A010941 to the PLL1 address, then 0x0A010940 to the same address, then the divider off, then the reference clock set to the TX input, then the RMII external TX clock set to PLL1. In PHY role only the divider-off write and the reference-clock write remain.
- R5: In RGMII mode (code 2) the speed code (0 none, 1 = 10, 2 = 100, 3 = 1000 Mb/s) selects the writes. At speed 3 the writes are: divider off, then the RGMII TX clock from PLL0. At speed 2 they are: divider on with factor 1, then the TX clock from the divider output. At speed 1 they are: divider on with factor 10, then the TX clock from the divider output. In each of these three cases the TX pad word 0x1A1A1A1A follows. At speed 0 all clock and TX pad writes are skipped and no error is raised.
- R6: SGMII mode (code 3) issues no clock writes. Every accepted port, whatever its mode, ends with the RX pad word 0x02020312.
- R7: The address for slot s of port p is `addr_tbl_i[(p*10+s)*AW +: AW]`. The slots are: 0 divider, 1 MII TX clock, 2 MII RX clock, 3 reference clock, 4 RGMII TX clock, 5 TX pad, 6 MII external TX clock, 7 MII external RX clock, 8 RMII external TX clock, 9 RX pad. If the selected address (or `pll_addr_i` for a PLL write) equals the reserved marker, that write is skipped and the sequence carries on. No request ever carries the marker.
- R8: Ports are handled in ascending order. A run produces exactly one `done_o` pulse, one cycle long, and `busy_o` is low in that cycle. `busy_o` is high whenever a request is pending. A start pulse while busy is ignored.
- R9: Mode codes 4–7 are illegal. In RGMII mode, speed codes 4–7 are also illegal. When the sequencer reaches a port with an illegal setting, it stops before issuing any write for that port and raises `done_o` and `error_o` together. Writes already issued for earlier ports stand.
- R10: If `req_err_i` is high on the edge that completes a write, the run ends: no further request is made, and `done_o` and `error_o` pulse on the next cycle.
- R11: During and after reset, `req_valid_o`, `busy_o`, `done_o` and `error_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| port_mode_i | input | NPORT*3 | Interface mode per port, port p at bits [3p+2:3p] |
| port_phy_i | input | NPORT | Role per port: 1 = PHY, 0 = MAC |
| port_speed_i | input | NPORT*3 | Speed code per port, port p at bits [3p+2:3p] |
| addr_tbl_i | input | NPORT*10*AW | Per-port register address table |
| pll_addr_i | input | AW | Address of the shared PLL1 control register |
| req_valid_o | output | 1 | Write request pending |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_addr_o | output | AW | Write address |
| req_data_o | output | 32 | Write data |
| req_err_i | input | 1 | Error response, sampled together with the handshake |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | Run aborted, pulses with done |

## Verification
The bench builds the block with NPORT=5 and AW=16, and uses the all-ones reserved marker. With five ports every port index from 0 to 4 appears in the source codes, up to divider output 0x15 and TX input 0x08. This also reaches the highest port number, which ends each run. The 16-bit addresses keep the table small while still allowing the bench to set a distinct address for every slot and to mark any chosen slot or the PLL1 entry as reserved.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  localparam int NSTEP = 12;
  localparam int NSLOT = 10;

  localparam logic [2:0] IFM_MII   = 3'd0;
  localparam logic [2:0] IFM_RMII  = 3'd1;
  localparam logic [2:0] IFM_RGMII = 3'd2;
  localparam logic [2:0] IFM_SGMII = 3'd3;

  localparam logic [2:0] SPD_NONE = 3'd0;
  localparam logic [2:0] SPD_10   = 3'd1;
  localparam logic [2:0] SPD_100  = 3'd2;
  localparam logic [2:0] SPD_1000 = 3'd3;

  localparam logic [4:0] SRC_PLL0    = 5'h0B;
  localparam logic [4:0] SRC_PLL1    = 5'h0E;
  localparam logic [4:0] SRC_DIVOUT0 = 5'h11;
  localparam logic [4:0] SRC_XTAL    = 5'h0A;

  localparam logic [31:0] PLL_LOAD_WORD = 32'h0A01_0941;
  localparam logic [31:0] PLL_RUN_WORD  = 32'h0A01_0940;
  localparam logic [31:0] PAD_TX_WORD   = 32'h1A1A_1A1A;
  localparam logic [31:0] PAD_RX_WORD   = 32'h0202_0312;

  // Global step order; every mode's write order is a subsequence of it.
  // Steps from ST_DIV onward map to table slot (step - 2).
  typedef enum logic [3:0] {
    ST_PLL_CFG = 4'd0,
    ST_PLL_ON  = 4'd1,
    ST_DIV     = 4'd2,
    ST_MTX     = 4'd3,
    ST_MRX     = 4'd4,
    ST_REF     = 4'd5,
    ST_RGTX    = 4'd6,
    ST_PADTX   = 4'd7,
    ST_MEXTTX  = 4'd8,
    ST_MEXTRX  = 4'd9,
    ST_REXTTX  = 4'd10,
    ST_PADRX   = 4'd11
  } step_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_SCAN  = 2'd1,
    FS_ISSUE = 2'd2
  } fsm_e;

  function automatic logic [31:0] route_word(input logic [4:0] src);
    logic [31:0] w;
    w        = '0;
    w[28:24] = src;
    w[11]    = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] div_word(input logic run, input logic [3:0] ratio_m1);
    logic [31:0] w;
    w        = '0;
    w[28:24] = SRC_XTAL;
    w[11]    = 1'b1;
    w[5:2]   = ratio_m1;
    w[0]     = ~run;
    return w;
  endfunction

endpackage

// File: rtl/clkseq_plan.sv
module clkseq_plan
  import clkseq_pkg::*;
(
  input  logic [2:0]       mode_i,
  input  logic             phy_i,
  input  logic [2:0]       speed_i,
  output logic [NSTEP-1:0] step_en_o,
  output logic             cfg_bad_o
);

  always_comb begin
    step_en_o = '0;
    cfg_bad_o = 1'b0;
    case (mode_i)
      IFM_MII: begin
        step_en_o[ST_DIV]    = 1'b1;
        step_en_o[ST_MTX]    = 1'b1;
        step_en_o[ST_MRX]    = 1'b1;
        step_en_o[ST_MEXTTX] = phy_i;
        step_en_o[ST_MEXTRX] = phy_i;
      end
      IFM_RMII: begin
        step_en_o[ST_PLL_CFG] = ~phy_i;
        step_en_o[ST_PLL_ON]  = ~phy_i;
        step_en_o[ST_DIV]     = 1'b1;
        step_en_o[ST_REF]     = 1'b1;
        step_en_o[ST_REXTTX]  = ~phy_i;
      end
      IFM_RGMII: begin
        case (speed_i)
          SPD_NONE: ;
          SPD_10, SPD_100, SPD_1000: begin
            step_en_o[ST_DIV]   = 1'b1;
            step_en_o[ST_RGTX]  = 1'b1;
            step_en_o[ST_PADTX] = 1'b1;
          end
          default: cfg_bad_o = 1'b1;
        endcase
      end
      IFM_SGMII: ;
      default: cfg_bad_o = 1'b1;
    endcase
    step_en_o[ST_PADRX] = ~cfg_bad_o;
  end

endmodule

// File: rtl/clkseq_word.sv
module clkseq_word
  import clkseq_pkg::*;
#(
  parameter int PW = 3
) (
  input  step_e          step_i,
  input  logic [PW-1:0]  port_i,
  input  logic [2:0]     mode_i,
  input  logic           phy_i,
  input  logic [2:0]     speed_i,
  output logic [31:0]    data_o
);

  logic [4:0]  pidx;
  logic [4:0]  tx_in;
  logic [4:0]  rx_in;
  logic [4:0]  div_out;
  logic [31:0] div_cfg;

  always_comb begin
    pidx    = 5'(port_i);
    tx_in   = {pidx[3:0], 1'b0};
    rx_in   = {pidx[3:0], 1'b1};
    div_out = SRC_DIVOUT0 + pidx;
  end

  always_comb begin
    div_cfg = div_word(1'b0, 4'd0);
    if (mode_i == IFM_MII) begin
      div_cfg = div_word(phy_i, 4'd0);
    end else if (mode_i == IFM_RGMII) begin
      if (speed_i == SPD_100)     div_cfg = div_word(1'b1, 4'd0);
      else if (speed_i == SPD_10) div_cfg = div_word(1'b1, 4'd9);
    end
  end

  always_comb begin
    case (step_i)
      ST_PLL_CFG: data_o = PLL_LOAD_WORD;
      ST_PLL_ON:  data_o = PLL_RUN_WORD;
      ST_DIV:     data_o = div_cfg;
      ST_MTX:     data_o = route_word(phy_i ? div_out : tx_in);
      ST_MRX:     data_o = route_word(rx_in);
      ST_REF:     data_o = route_word(tx_in);
      ST_RGTX:    data_o = route_word((speed_i == SPD_1000) ? SRC_PLL0 : div_out);
      ST_PADTX:   data_o = PAD_TX_WORD;
      ST_MEXTTX:  data_o = route_word(div_out);
      ST_MEXTRX:  data_o = route_word(div_out);
      ST_REXTTX:  data_o = route_word(SRC_PLL1);
      ST_PADRX:   data_o = PAD_RX_WORD;
      default:    data_o = '0;
    endcase
  end

endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int PW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_bad_i,
  input  logic          step_hit_i,
  input  logic          ready_i,
  input  logic          rsp_err_i,
  output logic [PW-1:0] port_o,
  output step_e         step_o,
  output logic          valid_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);

  localparam logic [PW-1:0] PORT_LAST = PW'(NPORT - 1);

  fsm_e          state_q;
  logic [PW-1:0] port_q;
  step_e         step_q;
  logic          done_q;
  logic          err_q;

  logic abort;
  logic move;
  logic last_step;
  logic last_port;

  always_comb begin
    last_step = (step_q == ST_PADRX);
    last_port = (port_q == PORT_LAST);
    abort     = ((state_q == FS_SCAN) && cfg_bad_i) ||
                ((state_q == FS_ISSUE) && ready_i && rsp_err_i);
    move      = ((state_q == FS_SCAN) && !cfg_bad_i && !step_hit_i) ||
                ((state_q == FS_ISSUE) && ready_i && !rsp_err_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      port_q  <= '0;
      step_q  <= ST_PLL_CFG;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (abort) begin
        state_q <= FS_IDLE;
        done_q  <= 1'b1;
        err_q   <= 1'b1;
      end else if (move) begin
        if (last_step) begin
          if (last_port) begin
            state_q <= FS_IDLE;
            done_q  <= 1'b1;
          end else begin
            port_q  <= port_q + 1'b1;
            step_q  <= ST_PLL_CFG;
            state_q <= FS_SCAN;
          end
        end else begin
          step_q  <= step_e'(4'(step_q) + 4'd1);
          state_q <= FS_SCAN;
        end
      end else if (state_q == FS_SCAN && step_hit_i) begin
        state_q <= FS_ISSUE;
      end else if (state_q == FS_IDLE && start_i) begin
        state_q <= FS_SCAN;
        port_q  <= '0;
        step_q  <= ST_PLL_CFG;
      end
    end
  end

  assign port_o  = port_q;
  assign step_o  = step_q;
  assign valid_o = (state_q == FS_ISSUE);
  assign busy_o  = (state_q != FS_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;

endmodule

// File: rtl/clk_setup_seq.sv
module clk_setup_seq
  import clkseq_pkg::*;
#(
  parameter int             NPORT    = 5,
  parameter int             AW       = 24,
  parameter logic [AW-1:0]  RSV_ADDR = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NPORT*3-1:0]       port_mode_i,
  input  logic [NPORT-1:0]         port_phy_i,
  input  logic [NPORT*3-1:0]       port_speed_i,
  input  logic [NPORT*NSLOT*AW-1:0] addr_tbl_i,
  input  logic [AW-1:0]            pll_addr_i,
  output logic                     req_valid_o,
  input  logic                     req_ready_i,
  output logic [AW-1:0]            req_addr_o,
  output logic [31:0]              req_data_o,
  input  logic                     req_err_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     error_o
);

  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [2:0]    mode_a  [NPORT];
  logic [2:0]    speed_a [NPORT];
  logic [AW-1:0] addr_a  [NPORT][NSLOT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign mode_a[p]  = port_mode_i[p*3 +: 3];
    assign speed_a[p] = port_speed_i[p*3 +: 3];
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign addr_a[p][s] = addr_tbl_i[(p*NSLOT+s)*AW +: AW];
    end
  end

  logic [PW-1:0]    cur_port;
  step_e            cur_step;
  logic [2:0]       cur_mode;
  logic [2:0]       cur_speed;
  logic             cur_phy;
  logic [NSTEP-1:0] step_en;
  logic             cfg_bad;
  logic             is_pll;
  logic [3:0]       slot;
  logic [AW-1:0]    cur_addr;
  logic             step_hit;

  always_comb begin
    cur_mode  = mode_a[cur_port];
    cur_speed = speed_a[cur_port];
    cur_phy   = port_phy_i[cur_port];
    is_pll    = (cur_step == ST_PLL_CFG) || (cur_step == ST_PLL_ON);
    slot      = is_pll ? 4'd0 : (4'(cur_step) - 4'd2);
    cur_addr  = is_pll ? pll_addr_i : addr_a[cur_port][slot];
    step_hit  = step_en[cur_step] && (cur_addr != RSV_ADDR);
  end

  clkseq_plan u_plan (
    .mode_i    (cur_mode),
    .phy_i     (cur_phy),
    .speed_i   (cur_speed),
    .step_en_o (step_en),
    .cfg_bad_o (cfg_bad)
  );

  clkseq_word #(.PW(PW)) u_word (
    .step_i  (cur_step),
    .port_i  (cur_port),
    .mode_i  (cur_mode),
    .phy_i   (cur_phy),
    .speed_i (cur_speed),
    .data_o  (req_data_o)
  );

  clkseq_ctrl #(.NPORT(NPORT), .PW(PW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cfg_bad_i  (cfg_bad),
    .step_hit_i (step_hit),
    .ready_i    (req_ready_i),
    .rsp_err_i  (req_err_i),
    .port_o     (cur_port),
    .step_o     (cur_step),
    .valid_o    (req_valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .error_o    (error_o)
  );

  assign req_addr_o = cur_addr;

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
  parameter int            AW       = 24,
  parameter logic [AW-1:0] RSV_ADDR = '1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic [31:0]   req_data_o,
  input logic          req_err_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          error_o
);

  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_data_o));

  // R7
  no_rsv_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_addr_o != RSV_ADDR);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy_o);

  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  // R10
  bus_err_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && req_err_i |=> !req_valid_o && done_o && error_o);

endmodule

bind clk_setup_seq clkseq_chk #(.AW(AW), .RSV_ADDR(RSV_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_data_o  (req_data_o),
  .req_err_i   (req_err_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o)
);

// File: tb/tb_clk_setup_seq.sv
module tb_clk_setup_seq;

  localparam int NP = 5;
  localparam int AW = 16;
  localparam int NS = 10;
  localparam logic [AW-1:0] RSV = '1;
  localparam logic [AW-1:0] PLL_A = 16'h0A00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NP*3-1:0]     mode_v;
  logic [NP*3-1:0]     speed_v;
  logic [NP-1:0]       phy_v;
  logic [NP*NS*AW-1:0] tbl_v;
  logic [AW-1:0]       pll_v;
  logic req_valid;
  logic req_ready = 1'b0;
  logic req_err = 1'b0;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_data;
  logic busy, done, error;

  logic [2:0] cm [NP];
  logic       cr [NP];
  logic [2:0] cs [NP];
  logic       rsv_m [NP][NS];
  logic       rsv_pll;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] rec_a [128];
  logic [31:0]   rec_d [128];
  int nrec = 0;
  int done_cnt = 0;
  bit err_seen = 0;
  bit bp = 0;
  bit inj_en = 0;
  int inj_idx = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0] ex_a [128];
  logic [31:0]   ex_d [128];
  int nexp;
  bit exp_err;

  always #2 clk = ~clk;

  clk_setup_seq #(.NPORT(NP), .AW(AW), .RSV_ADDR(RSV)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .port_mode_i  (mode_v),
    .port_phy_i   (phy_v),
    .port_speed_i (speed_v),
    .addr_tbl_i   (tbl_v),
    .pll_addr_i   (pll_v),
    .req_valid_o  (req_valid),
    .req_ready_i  (req_ready),
    .req_addr_o   (req_addr),
    .req_data_o   (req_data),
    .req_err_i    (req_err),
    .busy_o       (busy),
    .done_o       (done),
    .error_o      (error)
  );

  function automatic logic [AW-1:0] slot_addr(input int p, input int s);
    return AW'(16'h1000 + p*16 + s);
  endfunction

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      mode_v[p*3 +: 3]  = cm[p];
      speed_v[p*3 +: 3] = cs[p];
      phy_v[p]          = cr[p];
      for (int s = 0; s < NS; s++)
        tbl_v[(p*NS+s)*AW +: AW] = rsv_m[p][s] ? RSV : slot_addr(p, s);
    end
    pll_v = rsv_pll ? RSV : PLL_A;
  end

  // Drive ready/err mid-cycle, then record the handshake seen by the next edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
    req_err = inj_en && (nrec == inj_idx);
    #1;
    if (req_valid && req_ready) begin
      if (nrec < 128) begin
        rec_a[nrec] = req_addr;
        rec_d[nrec] = req_data;
      end
      nrec++;
    end
    if (done) begin
      done_cnt++;
      if (error) err_seen = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rw(input int src);
    return (32'(src) << 24) | 32'h0000_0800;
  endfunction

  function automatic logic [31:0] dw(input bit on, input int f);
    return 32'h0A00_0800 | (32'(f - 1) << 2) | (on ? 32'h0 : 32'h1);
  endfunction

  task automatic push(input logic [AW-1:0] a, input logic [31:0] d);
    if (a != RSV) begin
      ex_a[nexp] = a;
      ex_d[nexp] = d;
      nexp++;
    end
  endtask

  function automatic logic [AW-1:0] ta(input int p, input int s);
    return rsv_m[p][s] ? RSV : slot_addr(p, s);
  endfunction

  task automatic build_exp();
    logic [AW-1:0] pa;
    nexp = 0;
    exp_err = 0;
    pa = rsv_pll ? RSV : PLL_A;
    for (int p = 0; p < NP; p++) begin
      if (cm[p] > 3 || (cm[p] == 2 && cs[p] > 3)) begin
        exp_err = 1;
        break;
      end
      case (cm[p])
        0: begin
          push(ta(p, 0), dw(cr[p], 1));
          push(ta(p, 1), rw(cr[p] ? 17 + p : 2*p));
          push(ta(p, 2), rw(2*p + 1));
          if (cr[p]) begin
            push(ta(p, 6), rw(17 + p));
            push(ta(p, 7), rw(17 + p));
          end
        end
        1: begin
          if (!cr[p]) begin
            push(pa, 32'h0A01_0941);
            push(pa, 32'h0A01_0940);
          end
          push(ta(p, 0), dw(0, 1));
          push(ta(p, 3), rw(2*p));
          if (!cr[p]) push(ta(p, 8), rw(14));
        end
        2: begin
          if (cs[p] != 0) begin
            if (cs[p] == 3) begin
              push(ta(p, 0), dw(0, 1));
              push(ta(p, 4), rw(11));
            end else begin
              push(ta(p, 0), dw(1, (cs[p] == 1) ? 10 : 1));
              push(ta(p, 4), rw(17 + p));
            end
            push(ta(p, 5), 32'h1A1A_1A1A);
          end
        end
        default: ;
      endcase
      push(ta(p, 9), 32'h0202_0312);
    end
    if (inj_en && inj_idx < nexp) begin
      nexp = inj_idx + 1;
      exp_err = 1;
    end
  endtask

  task automatic clear_cfg();
    for (int p = 0; p < NP; p++) begin
      cm[p] = 3'd0;
      cr[p] = 1'b0;
      cs[p] = 3'd0;
      for (int s = 0; s < NS; s++) rsv_m[p][s] = 1'b0;
    end
    rsv_pll = 1'b0;
    bp = 0;
    inj_en = 0;
    inj_idx = 0;
  endtask

  task automatic run_and_check(input string tag, input bit extra);
    int n;
    nrec = 0;
    done_cnt = 0;
    err_seen = 0;
    build_exp();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (4) @(negedge clk);
      check(busy == 1'b1, {tag, " busy mid-run"}, 64'(busy), 64'd1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_cnt > 0) break;
    end
    repeat (8) @(negedge clk);
    check(nrec == nexp, {tag, " write count"}, 64'(nrec), 64'(nexp));
    n = (nrec < nexp) ? nrec : nexp;
    for (int i = 0; i < n; i++) begin
      check(rec_a[i] == ex_a[i], {tag, " address"}, 64'(rec_a[i]), 64'(ex_a[i]));
      check(rec_d[i] == ex_d[i], {tag, " data"}, 64'(rec_d[i]), 64'(ex_d[i]));
    end
    check(done_cnt == 1, {tag, " done pulses"}, 64'(done_cnt), 64'd1);
    check(err_seen == exp_err, {tag, " error flag"}, 64'(err_seen), 64'(exp_err));
    check(busy == 1'b0, {tag, " idle at end"}, 64'(busy), 64'd0);
  endtask

  task automatic t_reset();
    // R11
    check(req_valid == 1'b0, "R11 valid in reset", 64'(req_valid), 64'd0);
    check(busy == 1'b0, "R11 busy in reset", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_valid == 1'b0, "R11 valid after reset", 64'(req_valid), 64'd0);
    check(done == 1'b0, "R11 done after reset", 64'(done), 64'd0);
    check(error == 1'b0, "R11 error after reset", 64'(error), 64'd0);
    check(busy == 1'b0, "R11 busy after reset", 64'(busy), 64'd0);
  endtask

  task automatic t_mii();
    // R3 mixed roles under back-pressure (R1)
    clear_cfg();
    bp = 1;
    cr[1] = 1; cr[3] = 1; cr[4] = 1;
    run_and_check("R3 R1 MII", 0);
  endtask

  task automatic t_rmii();
    // R4
    clear_cfg();
    for (int p = 0; p < NP; p++) cm[p] = 3'd1;
    cr[1] = 1; cr[4] = 1;
    run_and_check("R4 RMII", 0);
  endtask

  task automatic t_rgmii();
    // R5 all speeds, R2 divide-by-10 word on port 4
    clear_cfg();
    bp = 1;
    for (int p = 0; p < NP; p++) cm[p] = 3'd2;
    cs[0] = 3'd3; cs[1] = 3'd2; cs[2] = 3'd1; cs[3] = 3'd0; cs[4] = 3'd1;
    run_and_check("R5 R2 RGMII", 0);
  endtask

  task automatic t_sgmii();
    // R6
    clear_cfg();
    for (int p = 0; p < NP; p++) cm[p] = 3'd3;
    cm[2] = 3'd0; cr[2] = 1;
    run_and_check("R6 SGMII", 0);
  endtask

  task automatic t_reserved();
    // R7
    clear_cfg();
    bp = 1;
    cm[0] = 3'd1;
    cr[1] = 1; rsv_m[1][1] = 1; rsv_m[1][7] = 1;
    rsv_m[2][9] = 1;
    cm[3] = 3'd2; cs[3] = 3'd3; rsv_m[3][5] = 1;
    rsv_pll = 1;
    run_and_check("R7 reserved skip", 0);
  endtask

  task automatic t_busy_start();
    // R8
    clear_cfg();
    cm[0] = 3'd1; cm[2] = 3'd2; cs[2] = 3'd2; cr[4] = 1;
    run_and_check("R8 start while busy", 1);
  endtask

  task automatic t_bad_mode();
    // R9
    clear_cfg();
    cm[2] = 3'd5;
    run_and_check("R9 illegal mode", 0);
  endtask

  task automatic t_bad_speed();
    // R9
    clear_cfg();
    cm[1] = 3'd2; cs[1] = 3'd6;
    run_and_check("R9 illegal speed", 0);
  endtask

  task automatic t_bus_err();
    // R10
    clear_cfg();
    bp = 1;
    inj_en = 1;
    inj_idx = 3;
    cr[0] = 1;
    run_and_check("R10 bus error", 0);
  endtask

  initial begin
    clear_cfg();
    t_reset();
    t_mii();
    t_rmii();
    t_rgmii();
    t_sgmii();
    t_reserved();
    t_busy_start();
    t_bad_mode();
    t_bad_speed();
    t_bus_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule